// File: doc/BRIEF.md
# Outbound Address Window Translator

The block sits on the outbound path of a bus bridge and rewrites each 64-bit request address through a small set of programmable windows. Every window holds four values: a match base, a remap base, a mask and an action word. The 64-bit values are each split into a low and a high 32-bit register. An address belongs to a window when the bits kept by the mask agree with the window's match value under that mask. For such an address, the masked upper bits are replaced by the remap value and the unmasked lower bits are kept. The low four bits of the action word tell the downstream logic which kind of transaction to issue.

Software programs the windows through a 32-bit register port. Bit 0 of the low match word enables a window. A window whose registers are all zero is therefore disabled. When no enabled window claims an address, the address goes out untouched and carries the action word held in a separate fallback register, which resets to plain memory access. If windows overlap, the one with the lowest index claims the address. The result, together with a hit flag and the winning index, appears one clock after the request.

Top module: `ob_xlate`

## Requirements
- R1: After reset, every configuration register reads as zero, every window is disabled, the fallback action is 0x0 (memory) and rsp_valid is low.
- R2: Window n occupies byte addresses 0x4C00 + 0x20*n. Its word offsets are 0x00 match low, 0x04 match high, 0x08 remap low, 0x0C remap high, 0x10 mask low, 0x14 mask high and 0x18 action. A written value reads back unchanged, except that the low 16 bits of the mask low word always read zero.
- R3: The fallback action register sits at 0x4CFC. A read of any other address (for example 0x4C1C or 0x4D00) returns zero, and a write there changes no register.
- R4: A window takes part in matching only while bit 0 of its match low word is 1. A window with that bit clear never produces a hit.
- R5: An address A hits window n when (A & mask) equals (match & mask), with bit 0 of match left out of the comparison.
- R6: On a hit, rsp_addr = (remap & mask) | (A & ~mask), rsp_action is that window's action word, rsp_type is its low 4 bits (0x0 memory, 0x4 IO, 0x8 config type 0, 0x9 config type 1, 0xC message), rsp_hit is 1 and rsp_win is the window index.
- R7: On a miss, rsp_addr equals A, rsp_action equals the fallback register, rsp_hit is 0 and rsp_win is 0.
- R8: When several enabled windows hit, the window with the lowest index is selected.
- R9: rsp_valid and the result fields follow req_valid exactly one cycle later, and back-to-back requests each produce their own result.
- R10: cfg_rdata presents the addressed register in the cycle after cfg_rd is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 16 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid one cycle after cfg_rd |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | An enabled window claimed the address |
| rsp_win | output | 3 | Index of the claiming window, 0 on a miss |
| rsp_addr | output | 64 | Translated address |
| rsp_type | output | 4 | Transaction type, low bits of the action word |
| rsp_action | output | 32 | Full action word of the window or the fallback |

## Verification
The assertions assume that the configuration does not change in the same cycle as a request whose result they check. They also assume that register accesses are word aligned, so that an access decodes to exactly one slot. The stimulus keeps to both assumptions. It reprograms windows only through whole write cycles that finish before each request, and it only uses addresses that are multiples of four. Random window sizes run from 64 KiB to 2^45 bytes, and about half of the random addresses are aimed inside a programmed window so that both the hit path and the miss path are exercised.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;

   localparam int XL_ADDR_W   = 64;
   localparam int XL_DATA_W   = 32;
   localparam int XL_TYPE_W   = 4;
   localparam int XL_SLOT_ACT = 'h18;
   localparam int XL_SPAN     = XL_SLOT_ACT + 4;

   typedef enum logic [XL_TYPE_W-1:0] {
      XT_MEM  = 4'h0,
      XT_IO   = 4'h4,
      XT_CFG0 = 4'h8,
      XT_CFG1 = 4'h9,
      XT_MSG  = 4'hC
   } xl_txn_e;

   typedef struct packed {
      logic [XL_ADDR_W-1:0] match;
      logic [XL_ADDR_W-1:0] remap;
      logic [XL_ADDR_W-1:0] mask;
      logic [XL_DATA_W-1:0] act;
   } win_cfg_t;

   function automatic int xl_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ob_xlate_regs.sv
module ob_xlate_regs
   import ob_xlate_pkg::*;
#(
   parameter int NUM_WIN        = 8,
   parameter int REG_AW         = 16,
   parameter int WIN_BASE       = 'h4C00,
   parameter int WIN_STRIDE     = 'h20,
   parameter int MASK_ZERO_BITS = 16
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [REG_AW-1:0]    addr,
   input  logic [XL_DATA_W-1:0] wdata,
   output logic [XL_DATA_W-1:0] rdata,
   output win_cfg_t             cfg [NUM_WIN],
   output logic [XL_DATA_W-1:0] def_act
);

   localparam int LAST_ACT = WIN_BASE + WIN_STRIDE * (NUM_WIN - 1) + XL_SLOT_ACT;
   localparam logic [REG_AW-1:0] DEF_A = REG_AW'(LAST_ACT + 4);
   localparam logic [XL_DATA_W-1:0] KEEP_LO =
      ~((XL_DATA_W'(1) << MASK_ZERO_BITS) - XL_DATA_W'(1));

   logic [XL_DATA_W-1:0] rd_word [NUM_WIN];
   logic [NUM_WIN-1:0]   win_sel;
   logic                 def_sel;
   logic [XL_DATA_W-1:0] rd_mux;

   assign def_sel = (addr == DEF_A);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [REG_AW-1:0] BASE_A = REG_AW'(WIN_BASE + WIN_STRIDE * w);

      logic [REG_AW-1:0]    rel;
      logic [2:0]           slot;
      logic [XL_ADDR_W-1:0] match_q;
      logic [XL_ADDR_W-1:0] remap_q;
      logic [XL_ADDR_W-1:0] mask_q;
      logic [XL_DATA_W-1:0] act_q;
      logic [XL_DATA_W-1:0] rd_w;

      assign rel        = addr - BASE_A;
      assign slot       = rel[4:2];
      assign win_sel[w] = (addr >= BASE_A) && (rel < REG_AW'(XL_SPAN)) &&
                          (addr[1:0] == 2'b00);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            match_q <= '0;
            remap_q <= '0;
            mask_q  <= '0;
            act_q   <= '0;
         end else if (wr_en && win_sel[w]) begin
            case (slot)
               3'd0:    match_q[31:0]  <= wdata;
               3'd1:    match_q[63:32] <= wdata;
               3'd2:    remap_q[31:0]  <= wdata;
               3'd3:    remap_q[63:32] <= wdata;
               3'd4:    mask_q[31:0]   <= wdata & KEEP_LO;
               3'd5:    mask_q[63:32]  <= wdata;
               3'd6:    act_q          <= wdata;
               default: ;
            endcase
         end
      end

      always_comb begin
         case (slot)
            3'd0:    rd_w = match_q[31:0];
            3'd1:    rd_w = match_q[63:32];
            3'd2:    rd_w = remap_q[31:0];
            3'd3:    rd_w = remap_q[63:32];
            3'd4:    rd_w = mask_q[31:0];
            3'd5:    rd_w = mask_q[63:32];
            3'd6:    rd_w = act_q;
            default: rd_w = '0;
         endcase
         if (!win_sel[w]) rd_w = '0;
      end

      assign rd_word[w] = rd_w;
      assign cfg[w]     = '{match: match_q, remap: remap_q, mask: mask_q, act: act_q};

      // R2: mask floor stays clear after any mask-low write
      p_mask_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && win_sel[w] && slot == 3'd4) |=> (mask_q[MASK_ZERO_BITS-1:0] == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 def_act <= XL_DATA_W'(XT_MEM);
      else if (wr_en && def_sel)  def_act <= wdata;
   end

   always_comb begin
      rd_mux = def_sel ? def_act : '0;
      for (int i = 0; i < NUM_WIN; i++) rd_mux |= rd_word[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end

   // R3: reads outside the map return zero
   p_unmapped_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !def_sel && win_sel == '0) |=> (rdata == '0));

   // R3: fallback register takes the written word
   p_default_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && def_sel) |=> (def_act == $past(wdata)));

   // R10: read data appears one cycle after the strobe
   p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && def_sel && !wr_en) |=> (rdata == $past(def_act)));

endmodule

// File: rtl/ob_xlate_match.sv
module ob_xlate_match
   import ob_xlate_pkg::*;
#(
   parameter int NUM_WIN = 8
)(
   input  logic [XL_ADDR_W-1:0] addr,
   input  win_cfg_t             cfg [NUM_WIN],
   output logic [NUM_WIN-1:0]   hit_vec,
   output logic [NUM_WIN-1:0]   en_vec
);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      logic [XL_ADDR_W-1:0] base_cmp;
      assign base_cmp   = {cfg[w].match[XL_ADDR_W-1:1], 1'b0};
      assign en_vec[w]  = cfg[w].match[0];
      assign hit_vec[w] = en_vec[w] &&
                          ((addr & cfg[w].mask) == (base_cmp & cfg[w].mask));
   end

endmodule

// File: rtl/ob_xlate_pick.sv
module ob_xlate_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
)(
   input  logic [N-1:0]     req,
   output logic [N-1:0]     gnt,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   assign gnt = req & (~req + N'(1));
   assign any = |req;

   if (N == 1) begin : g_single
      assign idx = '0;
   end else begin : g_multi
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++)
            if (gnt[i]) idx |= IDX_W'(i);
      end
   end

endmodule

// File: rtl/ob_xlate.sv
module ob_xlate
   import ob_xlate_pkg::*;
#(
   parameter int NUM_WIN        = 8,
   parameter int REG_AW         = 16,
   parameter int WIN_BASE       = 'h4C00,
   parameter int WIN_STRIDE     = 'h20,
   parameter int MASK_ZERO_BITS = 16,
   localparam int IDX_W         = xl_idx_w(NUM_WIN)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic                 cfg_rd,
   input  logic [REG_AW-1:0]    cfg_addr,
   input  logic [31:0]          cfg_wdata,
   output logic [31:0]          cfg_rdata,
   input  logic                 req_valid,
   input  logic [63:0]          req_addr,
   output logic                 rsp_valid,
   output logic                 rsp_hit,
   output logic [IDX_W-1:0]     rsp_win,
   output logic [63:0]          rsp_addr,
   output logic [3:0]           rsp_type,
   output logic [31:0]          rsp_action
);

   initial begin
      assert (NUM_WIN >= 1 && NUM_WIN <= 16)
         else $error("ob_xlate: NUM_WIN out of range");
      assert (WIN_STRIDE >= XL_SPAN && WIN_STRIDE % 4 == 0)
         else $error("ob_xlate: WIN_STRIDE overlaps windows");
      assert (MASK_ZERO_BITS >= 1 && MASK_ZERO_BITS <= 31)
         else $error("ob_xlate: MASK_ZERO_BITS out of range");
      assert (REG_AW >= 5 && WIN_BASE + WIN_STRIDE * NUM_WIN + 4 <= (1 << REG_AW))
         else $error("ob_xlate: register map exceeds address width");
   end

   win_cfg_t             cfg [NUM_WIN];
   logic [XL_DATA_W-1:0] def_act;
   logic [NUM_WIN-1:0]   hit_vec;
   logic [NUM_WIN-1:0]   en_vec;
   logic [NUM_WIN-1:0]   gnt;
   logic                 any_hit;
   logic [IDX_W-1:0]     win_idx;
   win_cfg_t             sel;
   logic [XL_ADDR_W-1:0] xl_addr;

   ob_xlate_regs #(
      .NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .WIN_BASE(WIN_BASE),
      .WIN_STRIDE(WIN_STRIDE), .MASK_ZERO_BITS(MASK_ZERO_BITS)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .rd_en(cfg_rd),
      .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
      .cfg(cfg), .def_act(def_act)
   );

   ob_xlate_match #(.NUM_WIN(NUM_WIN)) i_match (
      .addr(req_addr), .cfg(cfg), .hit_vec(hit_vec), .en_vec(en_vec)
   );

   ob_xlate_pick #(.N(NUM_WIN), .IDX_W(IDX_W)) i_pick (
      .req(hit_vec), .gnt(gnt), .any(any_hit), .idx(win_idx)
   );

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_WIN; i++)
         if (gnt[i]) sel = sel | cfg[i];
   end

   assign xl_addr = any_hit ? ((sel.remap & sel.mask) | (req_addr & ~sel.mask))
                            : req_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_win    <= '0;
         rsp_addr   <= '0;
         rsp_action <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_hit    <= any_hit;
            rsp_win    <= any_hit ? win_idx : '0;
            rsp_addr   <= xl_addr;
            rsp_action <= any_hit ? sel.act : def_act;
         end
      end
   end

   assign rsp_type = rsp_action[XL_TYPE_W-1:0];

   // R9: result valid trails the request by one cycle
   p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rsp_valid == $past(req_valid)));

   // R8: at most one window granted
   p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R8: no lower-indexed hit beside the grant
   p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0) |-> ((hit_vec & (gnt - NUM_WIN'(1))) == '0));

   // R7: miss leaves the address untouched
   p_miss_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !any_hit) |=> (rsp_addr == $past(req_addr) && !rsp_hit));

   // R4: only enabled windows can be reported
   p_hit_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && any_hit) |=> ((($past(en_vec) >> rsp_win) & NUM_WIN'(1)) != '0));

   // R6: offset bits below the mask floor survive translation
   p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && any_hit) |=>
         (rsp_addr[MASK_ZERO_BITS-1:0] == $past(req_addr[MASK_ZERO_BITS-1:0])));

endmodule

// File: tb/test_ob_xlate.sv
module test_ob_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
   logic [15:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic        rsp_valid, rsp_hit;
   logic [2:0]  rsp_win;
   logic [63:0] rsp_addr;
   logic [3:0]  rsp_type;
   logic [31:0] rsp_action;

   int checks = 0;
   int errors = 0;

   logic [63:0] mm [8];
   logic [63:0] mr [8];
   logic [63:0] mk [8];
   logic [31:0] ma [8];
   logic [31:0] mdef;

   always #5 clk = ~clk;

   ob_xlate i_ob_xlate (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_addr(rsp_addr),
      .rsp_type(rsp_type), .rsp_action(rsp_action)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_rd(input logic [15:0] a);
      int w, o;
      if (a == 16'h4CFC) return mdef;
      if (a < 16'h4C00 || a >= 16'h4D00 || a[1:0] != 0) return '0;
      w = int'(a - 16'h4C00) >> 5;
      o = int'(a - 16'h4C00) & 31;
      case (o)
         'h00: return mm[w][31:0];
         'h04: return mm[w][63:32];
         'h08: return mr[w][31:0];
         'h0C: return mr[w][63:32];
         'h10: return mk[w][31:0];
         'h14: return mk[w][63:32];
         'h18: return ma[w];
         default: return '0;
      endcase
   endfunction

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      int w, o;
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (a == 16'h4CFC) mdef = d;
      else if (a >= 16'h4C00 && a < 16'h4D00 && a[1:0] == 0) begin
         w = int'(a - 16'h4C00) >> 5;
         o = int'(a - 16'h4C00) & 31;
         case (o)
            'h00: mm[w][31:0]  = d;
            'h04: mm[w][63:32] = d;
            'h08: mr[w][31:0]  = d;
            'h0C: mr[w][63:32] = d;
            'h10: mk[w][31:0]  = d & 32'hFFFF_0000;
            'h14: mk[w][63:32] = d;
            'h18: ma[w]        = d;
            default: ;
         endcase
      end
   endtask

   task automatic rd_chk(input logic [15:0] a, input string tag);
      @(negedge clk);
      cfg_rd = 1'b1; cfg_addr = a;
      @(negedge clk);
      cfg_rd = 1'b0;
      check(tag, 64'(cfg_rdata), 64'(model_rd(a)));
   endtask

   task automatic set_win(input int w, input logic [63:0] m, input logic [63:0] r,
                          input logic [63:0] k, input logic [31:0] act);
      logic [15:0] b;
      b = 16'h4C00 + 16'(w * 32);
      wr(b + 16'h00, m[31:0]);  wr(b + 16'h04, m[63:32]);
      wr(b + 16'h08, r[31:0]);  wr(b + 16'h0C, r[63:32]);
      wr(b + 16'h10, k[31:0]);  wr(b + 16'h14, k[63:32]);
      wr(b + 16'h18, act);
   endtask

   function automatic logic [134:0] expect_of(input logic [63:0] a);
      // {hit, win[2:0], addr[63:0], action[31:0], pad}
      for (int w = 0; w < 8; w++)
         if (mm[w][0] && ((a & mk[w]) == ({mm[w][63:1], 1'b0} & mk[w])))
            return {1'b1, 3'(w), (mr[w] & mk[w]) | (a & ~mk[w]), ma[w], 35'd0};
      return {1'b0, 3'd0, a, mdef, 35'd0};
   endfunction

   task automatic cmp_rsp(input logic [63:0] a, input logic [134:0] e, input string note);
      string tag;
      tag = e[134] ? {"R6 ", note} : {"R7 ", note};
      check({tag, " valid R9"}, 64'(rsp_valid), 64'd1);
      check({tag, " hit"}, 64'(rsp_hit), 64'(e[134]));
      check({tag, " win"}, 64'(rsp_win), 64'(e[133:131]));
      check({tag, " addr"}, rsp_addr, e[130:67]);
      check({tag, " action"}, 64'(rsp_action), 64'(e[66:35]));
      check({tag, " type"}, 64'(rsp_type), 64'(e[38:35]));
   endtask

   task automatic req_chk(input logic [63:0] a, input string note);
      logic [134:0] e;
      e = expect_of(a);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      cmp_rsp(a, e, note);
   endtask

   task automatic summary;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      logic [134:0] e1, e2;
      logic [63:0]  a1, a2;
      void'($urandom(32'd20240611));
      for (int w = 0; w < 8; w++) begin
         mm[w] = '0; mr[w] = '0; mk[w] = '0; ma[w] = '0;
      end
      mdef = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
      rd_chk(16'h4C00, "R1 match low win0");
      rd_chk(16'h4CF8, "R1 action win7");
      rd_chk(16'h4CFC, "R1 fallback action");
      req_chk(64'h0000_0000_0000_0000, "R1 R4 reset miss");

      // R2 / R10: register map readback
      set_win(3, 64'h1234_5678_9ABC_DEF1, 64'hCAFE_0000_1111_0000,
              64'hFFFF_FFFF_FFFF_FFFF, 32'hA5A5_0004);
      for (int o = 0; o < 28; o += 4)
         rd_chk(16'h4C60 + 16'(o), "R2 R10 readback win3");
      check("R2 mask floor", 64'(mk[3][15:0]), 64'd0);

      // R3: fallback register and unmapped space
      wr(16'h4CFC, 32'h0000_000C);
      rd_chk(16'h4CFC, "R3 fallback");
      wr(16'h4C1C, 32'hDEAD_BEEF);
      wr(16'h4D00, 32'hDEAD_BEEF);
      rd_chk(16'h4C1C, "R3 gap slot");
      rd_chk(16'h4D00, "R3 beyond map");
      rd_chk(16'h4C00, "R3 neighbour untouched");
      req_chk(64'h7777_0000_0000_0042, "R3 miss uses new fallback");
      wr(16'h4CFC, 32'h0);
      set_win(3, 64'h0, 64'h0, 64'h0, 32'h0);

      // R8 / R5: overlapping windows, lowest index wins
      set_win(2, 64'h0000_0001_0000_0001, 64'h0000_00AB_0000_0000,
              64'hFFFF_FFFF_FFF0_0000, 32'h4);
      set_win(5, 64'h0000_0001_0000_0001, 64'h0000_00CD_0000_0000,
              64'hFFFF_FFFF_0000_0000, 32'h9);
      req_chk(64'h0000_0001_0003_4560, "R8 overlap picks win2");
      req_chk(64'h0000_0001_00F3_4560, "R8 outside win2 falls to win5");

      // R4: clear enable of window 2, window 5 takes over
      wr(16'h4C40, 32'h0000_0000);
      req_chk(64'h0000_0001_0003_4560, "R4 disabled win2");

      // R9: back-to-back requests
      a1 = 64'h0000_0001_0000_1000;
      a2 = 64'h0000_0009_0000_2000;
      e1 = expect_of(a1);
      e2 = expect_of(a2);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a1;
      @(negedge clk);
      req_addr = a2;
      cmp_rsp(a1, e1, "R9 first of pair");
      @(negedge clk);
      req_valid = 1'b0;
      cmp_rsp(a2, e2, "R9 second of pair");
      @(negedge clk);
      check("R9 valid drops", 64'(rsp_valid), 64'd0);

      // random configurations and requests
      for (int round = 0; round < 4; round++) begin
         for (int w = 0; w < 8; w++) begin
            int k;
            logic [63:0] msk, m, r;
            logic [31:0] act;
            logic [3:0]  ty;
            k   = 16 + int'($urandom % 30);
            msk = ~((64'd1 << k) - 64'd1);
            m   = {$urandom, $urandom} & msk;
            if ($urandom % 4 != 0) m[0] = 1'b1;
            r   = {$urandom, $urandom};
            case ($urandom % 5)
               0: ty = 4'h0; 1: ty = 4'h4; 2: ty = 4'h8; 3: ty = 4'h9; default: ty = 4'hC;
            endcase
            act = {$urandom} & 32'hFFFF_FFF0 | 32'(ty);
            set_win(w, m, r, msk, act);
         end
         wr(16'h4CFC, $urandom & 32'hFFFF_FFF0);
         for (int n = 0; n < 60; n++) begin
            int w;
            logic [63:0] a;
            w = int'($urandom % 8);
            a = {$urandom, $urandom};
            if ($urandom % 2 == 0) a = (mm[w] & mk[w]) | (a & ~mk[w]);
            req_chk(a, "R5 random");
         end
      end

      summary();
      $finish;
   end

endmodule